// File: doc/BRIEF.md
# Hierarchical Cluster Power Domain Controller

This block sequences the power enables of a many-core array arranged as a two-level tree. At the leaves are clusters of cores, and clusters are gathered into groups. Each group also has a shared domain that holds its interconnect router and memory controller. Each leaf of the array is seen only through a per-core idle flag. A single request port takes one command per cycle: power a cluster up, power a cluster down, power a group up, or power a group down.

The controller keeps the tree consistent. A cluster can be powered only while its group's shared domain is powered. The shared domain comes up before any of its clusters, and goes down only after all of its clusters are cut. A stop is accepted only when every core it affects reports idle. Every request is answered one cycle later with an accept pulse or a reject pulse. Any rejection sets a sticky error flag that only reset clears. The power enables themselves serve as the status: one bit per cluster and one bit per group.

Top module: `hier_pwr_ctrl`

## Requirements
- R1: After reset every cluster enable and group enable is 0, neither the accept pulse nor the reject pulse is set, and the sticky error is 0.
- R2: Opcode 0 (cluster up) on cluster index c, while the group c/4 is on and no sequence is running, sets bit c of the cluster enables at the sampling edge and pulses accept for one cycle.
- R3: Opcode 0 on a cluster whose group is off is rejected and leaves every enable unchanged (inclusion rule).
- R4: Opcode 1 (cluster down) on cluster c is accepted and clears bit c only when cores 4c to 4c+3 all report idle; otherwise it is rejected and the cluster stays on.
- R5: Opcode 2 (group up) on group g sets group bit g at the sampling edge, and sets cluster bits 4g to 4g+3 at the following edge.
- R6: Opcode 3 (group down) on group g is accepted only when cores 16g to 16g+15 all report idle. It clears cluster bits 4g to 4g+3 at the sampling edge and group bit g at the following edge; otherwise it is rejected with no change.
- R7: A request presented in the cycle between the two steps of a group sequence is rejected and changes no enable.
- R8: A rejection sets the sticky error, which then stays 1 through later accepted requests until reset. Accept and reject are never set together.
- R9: A group opcode whose index is 4 or more (no such group) is rejected.
- R10: At no time is a cluster enable 1 while its group enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_idle | input | 64 | Idle flag per core; core k belongs to cluster k/4 |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 cluster up, 1 cluster down, 2 group up, 3 group down |
| req_idx | input | 4 | Cluster index for cluster ops, group index for group ops |
| req_ack | output | 1 | One-cycle pulse: previous request accepted |
| req_rej | output | 1 | One-cycle pulse: previous request rejected |
| err_sticky | output | 1 | Set by any rejection, cleared by reset |
| cl_pwr_en | output | 16 | Power enable per cluster |
| grp_pwr_en | output | 4 | Power enable per group shared domain |

## Verification
The idleness checks on power-down take for granted that the idle flags seen at the request edge are the ones that justify the cut. The bench therefore changes core_idle only on falling edges between requests, never inside a request cycle. The ordering checks assume nothing outside the block toggles the enables. Requests are driven for exactly one cycle on a falling edge, and the intrusion case for R7 is placed in the single gap cycle of a group sequence. Expected enables, accept and reject are computed in the bench from a per-group and per-cluster model, using the index arithmetic stated in the requirements.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
   typedef enum logic [1:0] {
      OP_CL_UP   = 2'd0,
      OP_CL_DN   = 2'd1,
      OP_GRP_UP  = 2'd2,
      OP_GRP_DN  = 2'd3
   } pdc_op_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_UP2  = 2'd1,
      PH_DN2  = 2'd2
   } pdc_phase_e;
endpackage

// File: rtl/pdc_idle_tree.sv
module pdc_idle_tree #(
   parameter int NUM_GROUPS   = 4,
   parameter int CL_PER_GRP   = 4,
   parameter int CORES_PER_CL = 4,
   localparam int NUM_CL      = NUM_GROUPS * CL_PER_GRP,
   localparam int NUM_CORES   = NUM_CL * CORES_PER_CL
) (
   input  logic [NUM_CORES-1:0]  core_idle,
   input  logic [NUM_GROUPS-1:0] grp_en,
   output logic [NUM_CL-1:0]     cl_idle,
   output logic [NUM_CL-1:0]     cl_parent_on,
   output logic [NUM_GROUPS-1:0] grp_idle
);
   for (genvar c = 0; c < NUM_CL; c++) begin : g_cl
      assign cl_idle[c]      = &core_idle[c*CORES_PER_CL +: CORES_PER_CL];
      assign cl_parent_on[c] = grp_en[c / CL_PER_GRP];
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign grp_idle[g] = &cl_idle[g*CL_PER_GRP +: CL_PER_GRP];
   end
endmodule

// File: rtl/pdc_req_check.sv
module pdc_req_check
   import pdc_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int CL_PER_GRP = 4,
   localparam int NUM_CL    = NUM_GROUPS * CL_PER_GRP,
   localparam int IDX_W     = $clog2(NUM_CL)
) (
   input  logic                  busy,
   input  pdc_op_e               op,
   input  logic [IDX_W-1:0]      idx,
   input  logic [NUM_CL-1:0]     cl_idle,
   input  logic [NUM_CL-1:0]     cl_parent_on,
   input  logic [NUM_GROUPS-1:0] grp_idle,
   output logic                  ok
);
   logic cl_hit_up, cl_hit_dn, grp_hit_up, grp_hit_dn;

   always_comb begin
      cl_hit_up  = 1'b0;
      cl_hit_dn  = 1'b0;
      grp_hit_up = 1'b0;
      grp_hit_dn = 1'b0;
      for (int c = 0; c < NUM_CL; c++) begin
         if (idx == IDX_W'(c)) begin
            cl_hit_up = cl_parent_on[c];
            cl_hit_dn = cl_idle[c];
         end
      end
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (idx == IDX_W'(g)) begin
            grp_hit_up = 1'b1;
            grp_hit_dn = grp_idle[g];
         end
      end
      unique case (op)
         OP_CL_UP:  ok = !busy && cl_hit_up;
         OP_CL_DN:  ok = !busy && cl_hit_dn;
         OP_GRP_UP: ok = !busy && grp_hit_up;
         default:   ok = !busy && grp_hit_dn;
      endcase
   end
endmodule

// File: rtl/pdc_seq.sv
module pdc_seq
   import pdc_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int CL_PER_GRP = 4,
   localparam int NUM_CL    = NUM_GROUPS * CL_PER_GRP,
   localparam int IDX_W     = $clog2(NUM_CL),
   localparam int GW        = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  pdc_op_e               op,
   input  logic [IDX_W-1:0]      idx,
   input  logic                  ok,
   input  logic [NUM_CL-1:0]     cl_idle,
   output logic                  busy,
   output logic                  ack,
   output logic                  rej,
   output logic                  err,
   output logic [NUM_CL-1:0]     cl_en,
   output logic [NUM_GROUPS-1:0] grp_en
);
   pdc_phase_e     phase;
   logic [GW-1:0]  pend;

   assign busy = (phase != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         pend   <= '0;
         ack    <= 1'b0;
         rej    <= 1'b0;
         err    <= 1'b0;
         cl_en  <= '0;
         grp_en <= '0;
      end else begin
         ack <= 1'b0;
         rej <= 1'b0;
         if (req_valid && !ok) begin
            rej <= 1'b1;
            err <= 1'b1;
         end
         unique case (phase)
            PH_UP2: begin
               for (int g = 0; g < NUM_GROUPS; g++)
                  if (pend == GW'(g))
                     for (int k = 0; k < CL_PER_GRP; k++)
                        cl_en[g*CL_PER_GRP + k] <= 1'b1;
               phase <= PH_IDLE;
            end
            PH_DN2: begin
               for (int g = 0; g < NUM_GROUPS; g++)
                  if (pend == GW'(g)) grp_en[g] <= 1'b0;
               phase <= PH_IDLE;
            end
            default: begin
               if (req_valid && ok) begin
                  ack <= 1'b1;
                  unique case (op)
                     OP_CL_UP, OP_CL_DN: begin
                        for (int c = 0; c < NUM_CL; c++)
                           if (idx == IDX_W'(c)) cl_en[c] <= (op == OP_CL_UP);
                     end
                     OP_GRP_UP: begin
                        for (int g = 0; g < NUM_GROUPS; g++)
                           if (idx == IDX_W'(g)) grp_en[g] <= 1'b1;
                        pend  <= GW'(idx);
                        phase <= PH_UP2;
                     end
                     default: begin
                        for (int g = 0; g < NUM_GROUPS; g++)
                           if (idx == IDX_W'(g))
                              for (int k = 0; k < CL_PER_GRP; k++)
                                 cl_en[g*CL_PER_GRP + k] <= 1'b0;
                        pend  <= GW'(idx);
                        phase <= PH_DN2;
                     end
                  endcase
               end
            end
         endcase
      end
   end

   // R8
   ack_rej_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack && rej));
   // R8
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(err) |-> err);
   // R7
   busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> rej);

   for (genvar c = 0; c < NUM_CL; c++) begin : g_chk
      // R10
      inclusion_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cl_en[c] |-> grp_en[c / CL_PER_GRP]);
      // R2
      up_under_parent_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(cl_en[c]) |-> $past(grp_en[c / CL_PER_GRP]));
      // R4
      down_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(cl_en[c]) |-> $past(cl_idle[c]));
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_gchk
      // R6
      leaves_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(grp_en[g]) |-> ($past(cl_en[g*CL_PER_GRP +: CL_PER_GRP]) == '0));
   end
endmodule

// File: rtl/hier_pwr_ctrl.sv
module hier_pwr_ctrl
   import pdc_pkg::*;
#(
   parameter int NUM_GROUPS   = 4,
   parameter int CL_PER_GRP   = 4,
   parameter int CORES_PER_CL = 4,
   localparam int NUM_CL      = NUM_GROUPS * CL_PER_GRP,
   localparam int NUM_CORES   = NUM_CL * CORES_PER_CL,
   localparam int IDX_W       = $clog2(NUM_CL)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_CORES-1:0]  core_idle,
   input  logic                  req_valid,
   input  logic [1:0]            req_op,
   input  logic [IDX_W-1:0]      req_idx,
   output logic                  req_ack,
   output logic                  req_rej,
   output logic                  err_sticky,
   output logic [NUM_CL-1:0]     cl_pwr_en,
   output logic [NUM_GROUPS-1:0] grp_pwr_en
);
   if (NUM_GROUPS < 1 || CL_PER_GRP < 1 || CORES_PER_CL < 1) begin : g_bad_size
      $error("hier_pwr_ctrl: every tree dimension must be at least 1");
   end
   if (NUM_CL < 2) begin : g_bad_cl
      $error("hier_pwr_ctrl: at least two clusters are required");
   end
   if (NUM_GROUPS > NUM_CL) begin : g_bad_idx
      $error("hier_pwr_ctrl: group index must fit in the request index");
   end

   logic [NUM_CL-1:0]     cl_idle, cl_parent_on;
   logic [NUM_GROUPS-1:0] grp_idle;
   logic                  busy, ok;
   pdc_op_e               op;

   assign op = pdc_op_e'(req_op);

   pdc_idle_tree #(
      .NUM_GROUPS(NUM_GROUPS), .CL_PER_GRP(CL_PER_GRP), .CORES_PER_CL(CORES_PER_CL)
   ) u_idle (
      .core_idle(core_idle), .grp_en(grp_pwr_en),
      .cl_idle(cl_idle), .cl_parent_on(cl_parent_on), .grp_idle(grp_idle)
   );

   pdc_req_check #(.NUM_GROUPS(NUM_GROUPS), .CL_PER_GRP(CL_PER_GRP)) u_check (
      .busy(busy), .op(op), .idx(req_idx), .cl_idle(cl_idle),
      .cl_parent_on(cl_parent_on), .grp_idle(grp_idle), .ok(ok)
   );

   pdc_seq #(.NUM_GROUPS(NUM_GROUPS), .CL_PER_GRP(CL_PER_GRP)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .idx(req_idx),
      .ok(ok), .cl_idle(cl_idle), .busy(busy), .ack(req_ack), .rej(req_rej),
      .err(err_sticky), .cl_en(cl_pwr_en), .grp_en(grp_pwr_en)
   );
endmodule

// File: tb/hier_pwr_ctrl_tb.sv
module hier_pwr_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] core_idle = '1;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = '0;
   logic [3:0]  req_idx = '0;
   logic        req_ack, req_rej, err_sticky;
   logic [15:0] cl_pwr_en;
   logic [3:0]  grp_pwr_en;

   logic [15:0] exp_cl = '0;
   logic [3:0]  exp_grp = '0;
   logic        exp_err = 1'b0;
   int checks = 0, failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hier_pwr_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .core_idle(core_idle), .req_valid(req_valid),
      .req_op(req_op), .req_idx(req_idx), .req_ack(req_ack), .req_rej(req_rej),
      .err_sticky(err_sticky), .cl_pwr_en(cl_pwr_en), .grp_pwr_en(grp_pwr_en)
   );

   task automatic chk(input bit good, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!good) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_state(input string req);
      chk(cl_pwr_en == exp_cl, req, 32'(cl_pwr_en), 32'(exp_cl));
      chk(grp_pwr_en == exp_grp, req, 32'(grp_pwr_en), 32'(exp_grp));
      chk(err_sticky == exp_err, req, 32'(err_sticky), 32'(exp_err));
   endtask

   function automatic bit model_ok(input int op, input int idx);
      case (op)
         0: return exp_grp[idx/4];
         1: return &core_idle[idx*4 +: 4];
         2: return idx < 4;
         default: return (idx < 4) && (&core_idle[(idx%4)*16 +: 16]);
      endcase
   endfunction

   // intrude: drive a cluster-up request in the gap cycle of a group sequence (R7)
   task automatic send(input int op, input int idx, input string req, input bit intrude);
      bit ok;
      ok = model_ok(op, idx);
      req_valid = 1'b1;
      req_op    = 2'(op);
      req_idx   = 4'(idx);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ack == ok, req, 32'(req_ack), 32'(ok));
      chk(req_rej == !ok, req, 32'(req_rej), 32'(!ok));
      if (!ok) exp_err = 1'b1;
      if (ok) begin
         case (op)
            0: exp_cl[idx] = 1'b1;
            1: exp_cl[idx] = 1'b0;
            2: exp_grp[idx] = 1'b1;
            default: exp_cl[idx*4 +: 4] = 4'h0;
         endcase
      end
      chk_state(req);
      if (ok && op >= 2) begin
         if (intrude) begin
            req_valid = 1'b1;
            req_op    = 2'd0;
            req_idx   = 4'(idx*4);
         end
         @(posedge clk);
         @(negedge clk);
         req_valid = 1'b0;
         if (op == 2) exp_cl[idx*4 +: 4] = 4'hF;
         else exp_grp[idx] = 1'b0;
         if (intrude) begin
            exp_err = 1'b1;
            chk(req_rej == 1'b1, "R7", 32'(req_rej), 32'd1);
            chk(req_ack == 1'b0, "R7", 32'(req_ack), 32'd0);
         end
         chk_state(req);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk_state("R1");
      chk(req_ack == 1'b0 && req_rej == 1'b0, "R1", 32'({req_ack, req_rej}), 32'd0);

      // R5: every group up with all accepted, error stays clear
      for (int g = 0; g < 4; g++) send(2, g, "R5", 1'b0);
      // R2/R4: cluster down then up, all idle
      for (int c = 0; c < 16; c++) begin
         send(1, c, "R4", 1'b0);
         send(0, c, "R2", 1'b0);
      end
      // R4: each core in turn busy blocks its own cluster only
      for (int k = 0; k < 64; k++) begin
         core_idle = ~(64'd1 << k);
         send(1, k/4, "R4", 1'b0);
         send(1, ((k/4)+1)%16, "R4", 1'b0);
         core_idle = '1;
         send(0, ((k/4)+1)%16, "R2", 1'b0);
      end
      // R6: one busy core per group blocks group down
      for (int g = 0; g < 4; g++) begin
         core_idle = ~(64'd1 << (g*16 + 5));
         send(3, g, "R6", 1'b0);
      end
      core_idle = '1;
      // R3: cluster up under off group, sweep all clusters after group down
      for (int g = 0; g < 4; g++) begin
         send(3, g, "R6", 1'b0);
         for (int k = 0; k < 4; k++) send(0, g*4 + k, "R3", 1'b0);
      end
      // R9: group index out of range
      for (int i = 4; i < 16; i++) send(2, i, "R9", 1'b0);
      send(3, 7, "R9", 1'b0);
      // R7: intrusion in the gap cycle of both sequence kinds
      send(2, 1, "R7", 1'b1);
      send(3, 1, "R7", 1'b1);
      // R8: error still held after accepted requests
      send(2, 2, "R8", 1'b0);
      chk(err_sticky == 1'b1, "R8", 32'(err_sticky), 32'd1);
      // R10: group down with a cluster left on, leaves first
      send(1, 9, "R10", 1'b0);
      send(3, 2, "R10", 1'b0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule